// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block is the digital control core of a multi-output clock generator. Its outputs are control signals only. It drives four output groups: the differential CPU pairs, a 33 MHz output, a pair of 48 MHz outputs and a reference output. For each group it produces a frequency code, a run enable and a tri-state control. It also produces the oscillator enable, the spread-spectrum request for the CPU pairs, the CPU current multiplier and a park-high level for the CPU true outputs. The oscillator, PLL and current-mode buffers sit outside the block and act on these controls.

Two pins are shared. They carry select straps while power-up reset is held. On the first clock after reset is released, their levels are captured into internal latches. After that the same pins carry the 48 MHz clocks. A hold counter keeps the 48 MHz drivers tri-stated while the capture completes, so that the drivers never fight the strap resistors. The live frequency-select input and the two latched straps form a 3-bit mode index. A fixed table decodes that index into per-group settings.

The active-low power-down input and the active-low spread input are synchronized to the reference clock. Power-down forces fixed levels on every group. When power-down ends, all groups stay disabled for a parameterized number of reference cycles while the oscillator and PLL settle.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: On the first clock edge after `rst_n` rises, `strap0_pin` and `strap1_pin` are latched. `mode_idx` is {`sel_hi`, latched strap0, latched strap1}, and `sel_hi` acts on it without delay.
- R2: Once latched, the strap values stay unchanged until the next reset, whatever toggles on the strap pins.
- R3: The 48 MHz group reports `usb_hiz`=1 during reset and for HOLD_CYCLES edges after the capture edge. It is released on edge HOLD_CYCLES+1 after reset release.
- R4: CPU frequency code: 1 (100 MHz) for modes 000, 001 and 010. 2 (133.3 MHz) for modes 100 and 101. 3 (200 MHz) for mode 110. When the CPU group runs, `cpu_en`=1 and `cpu_hiz`=0.
- R5: The 33 MHz group runs with code 4 in every defined mode except two. In mode 010 it is disabled (en=0, hiz=0). In mode 011 it is tri-stated.
- R6: The 48 MHz group runs with code 5 in modes 000, 100 and 110. It is disabled in modes 001, 010 and 101.
- R7: In mode 011 every group has hiz=1, en=0 and frequency code 0.
- R8: In mode 111 every group is disabled with code 0 and `rsvd_flag`=1. No output ever carries frequency code 7.
- R9: Power-down takes effect SYNC_STAGES edges after `pwrdn_n` falls. It does all of the following: `osc_en`=0, every group disabled and not tri-stated (driven low), `cpu_park_high`=1 and `cpu_imult`=2.
- R10: After `pwrdn_n` rises, every group stays disabled for SYNC_STAGES+STAB_CYCLES-1 edges, with `osc_en`=1. The mode settings return on edge SYNC_STAGES+STAB_CYCLES.
- R11: `cpu_spread`=1 exactly when the synchronized `spread_n` is low and the CPU group runs. The request reaches the output SYNC_STAGES edges after the input changes.
- R12: Outside power-down, `cpu_imult` follows `swing_sel`: 00 gives 5, 01 gives 6, 10 gives 4 and 11 gives 7.
- R13: The reference group runs with code 6 in every mode except two. It is tri-stated in mode 011 and disabled in mode 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| sel_hi | input | 1 | Frequency select, mode index bit 2 |
| strap0_pin | input | 1 | Shared strap pin sensed as mode index bit 1 |
| strap1_pin | input | 1 | Shared strap pin sensed as mode index bit 0 |
| pwrdn_n | input | 1 | Active-low power-down request |
| spread_n | input | 1 | Active-low spread-spectrum request |
| swing_sel | input | 2 | CPU current multiplier select |
| mode_idx | output | 3 | Decoded mode index |
| osc_en | output | 1 | Oscillator enable |
| cpu_freq | output | 3 | CPU pair frequency code |
| cpu_en | output | 1 | CPU pairs run |
| cpu_hiz | output | 1 | CPU pairs tri-stated |
| cpu_spread | output | 1 | Downspread enable for the CPU pairs |
| cpu_park_high | output | 1 | Hold CPU true outputs high |
| cpu_imult | output | 3 | CPU output current multiple of the reference |
| pci_freq | output | 3 | 33 MHz group frequency code |
| pci_en | output | 1 | 33 MHz output runs |
| pci_hiz | output | 1 | 33 MHz output tri-stated |
| usb_freq | output | 3 | 48 MHz group frequency code |
| usb_en | output | 1 | 48 MHz outputs run |
| usb_hiz | output | 1 | 48 MHz outputs tri-stated |
| ref_freq | output | 3 | Reference group frequency code |
| ref_en | output | 1 | Reference output runs |
| ref_hiz | output | 1 | Reference output tri-stated |
| rsvd_flag | output | 1 | Reserved mode selected |

## Verification
Power-down can take effect while the 48 MHz hold counter is still running after reset. In that window the two functions disagree about the 48 MHz pins: power-down asks for a low level, and the hold asks for tri-state. The bench releases reset with `pwrdn_n` already low. It then checks that the 48 MHz group stays tri-stated through the hold window, even though every other group is already forced low. After the hold ends, the 48 MHz group must switch to driven-low and not to running. The bench also checks that the latched straps survive the whole sequence.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef enum logic [2:0] {
    FQ_OFF = 3'd0,
    FQ_100 = 3'd1,
    FQ_133 = 3'd2,
    FQ_200 = 3'd3,
    FQ_33  = 3'd4,
    FQ_48  = 3'd5,
    FQ_REF = 3'd6
  } freq_t;

  typedef struct packed {
    freq_t freq;
    logic  en;
    logic  hiz;
  } grp_ctl_t;

  localparam int NGRP    = 4;
  localparam int GRP_CPU = 0;
  localparam int GRP_PCI = 1;
  localparam int GRP_USB = 2;
  localparam int GRP_REF = 3;

  localparam grp_ctl_t CTL_DIS = '{freq: FQ_OFF, en: 1'b0, hiz: 1'b0};
  localparam grp_ctl_t CTL_HIZ = '{freq: FQ_OFF, en: 1'b0, hiz: 1'b1};

  localparam logic [2:0] IMULT_PD = 3'd2;

endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkgen_strap.sv
module clkgen_strap #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin0,
  input  logic pin1,
  output logic cap_done,
  output logic lat0,
  output logic lat1,
  output logic hold_active
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_done <= 1'b0;
      lat0     <= 1'b0;
      lat1     <= 1'b0;
      hold_cnt <= '0;
    end else if (!cap_done) begin
      cap_done <= 1'b1;
      lat0     <= pin0;
      lat1     <= pin1;
      hold_cnt <= HW'(HOLD_CYCLES);
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign hold_active = !cap_done || (hold_cnt != '0);
endmodule

// File: rtl/clkgen_pwrseq.sv
module clkgen_pwrseq #(
  parameter int SYNC_STAGES = 2,
  parameter int STAB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrdn_n,
  input  logic spread_n,
  output logic pd_active,
  output logic stab_run,
  output logic spread_req
);
  localparam int SW = $clog2(STAB_CYCLES + 1);

  logic pd_sync_n, spread_sync_n;
  logic [SW-1:0] stab_cnt;

  clkgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk(clk), .rst_n(rst_n), .d(pwrdn_n), .q(pd_sync_n)
  );

  clkgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
    .clk(clk), .rst_n(rst_n), .d(spread_n), .q(spread_sync_n)
  );

  assign pd_active  = !pd_sync_n;
  assign spread_req = !spread_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              stab_cnt <= '0;
    else if (pd_active)      stab_cnt <= SW'(STAB_CYCLES);
    else if (stab_cnt != '0) stab_cnt <= stab_cnt - 1'b1;
  end

  assign stab_run = !pd_active && (stab_cnt != '0);
endmodule

// File: rtl/clkgen_decode.sv
module clkgen_decode
  import clkgen_pkg::*;
(
  input  logic [2:0] mode,
  output grp_ctl_t   ctl [NGRP],
  output logic       rsvd
);
  function automatic grp_ctl_t run(input freq_t f);
    return '{freq: f, en: 1'b1, hiz: 1'b0};
  endfunction

  always_comb begin
    rsvd = 1'b0;
    ctl[GRP_REF] = run(FQ_REF);
    ctl[GRP_PCI] = run(FQ_33);
    ctl[GRP_USB] = CTL_DIS;
    ctl[GRP_CPU] = run(FQ_100);
    unique case (mode)
      3'b000: ctl[GRP_USB] = run(FQ_48);
      3'b001: ;
      3'b010: ctl[GRP_PCI] = CTL_DIS;
      3'b011: begin
        for (int g = 0; g < NGRP; g++) ctl[g] = CTL_HIZ;
      end
      3'b100: begin
        ctl[GRP_CPU] = run(FQ_133);
        ctl[GRP_USB] = run(FQ_48);
      end
      3'b101: ctl[GRP_CPU] = run(FQ_133);
      3'b110: begin
        ctl[GRP_CPU] = run(FQ_200);
        ctl[GRP_USB] = run(FQ_48);
      end
      default: begin
        for (int g = 0; g < NGRP; g++) ctl[g] = CTL_DIS;
        rsvd = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
  import clkgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4,
  parameter int STAB_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_hi,
  input  logic       strap0_pin,
  input  logic       strap1_pin,
  input  logic       pwrdn_n,
  input  logic       spread_n,
  input  logic [1:0] swing_sel,
  output logic [2:0] mode_idx,
  output logic       osc_en,
  output logic [2:0] cpu_freq,
  output logic       cpu_en,
  output logic       cpu_hiz,
  output logic       cpu_spread,
  output logic       cpu_park_high,
  output logic [2:0] cpu_imult,
  output logic [2:0] pci_freq,
  output logic       pci_en,
  output logic       pci_hiz,
  output logic [2:0] usb_freq,
  output logic       usb_en,
  output logic       usb_hiz,
  output logic [2:0] ref_freq,
  output logic       ref_en,
  output logic       ref_hiz,
  output logic       rsvd_flag
);
  logic cap_done, lat0, lat1, hold_active;
  logic pd_active, stab_run, spread_req;
  logic dec_rsvd;
  grp_ctl_t dec [NGRP];
  grp_ctl_t fin [NGRP];

  clkgen_strap #(.HOLD_CYCLES(HOLD_CYCLES)) u_strap (
    .clk(clk), .rst_n(rst_n), .pin0(strap0_pin), .pin1(strap1_pin),
    .cap_done(cap_done), .lat0(lat0), .lat1(lat1), .hold_active(hold_active)
  );

  clkgen_pwrseq #(.SYNC_STAGES(SYNC_STAGES), .STAB_CYCLES(STAB_CYCLES)) u_pwr (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .spread_n(spread_n),
    .pd_active(pd_active), .stab_run(stab_run), .spread_req(spread_req)
  );

  assign mode_idx = {sel_hi, lat0, lat1};

  clkgen_decode u_dec (.mode(mode_idx), .ctl(dec), .rsvd(dec_rsvd));

  // Precedence: capture pending, power-down, settling, then the mode table.
  // The 48 MHz pins additionally stay tri-stated while the strap hold runs.
  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      if (!cap_done || pd_active || stab_run) fin[g] = CTL_DIS;
      else                                    fin[g] = dec[g];
      if (g == GRP_USB && hold_active)        fin[g] = CTL_HIZ;
    end
  end

  assign cpu_freq = fin[GRP_CPU].freq;
  assign cpu_en   = fin[GRP_CPU].en;
  assign cpu_hiz  = fin[GRP_CPU].hiz;
  assign pci_freq = fin[GRP_PCI].freq;
  assign pci_en   = fin[GRP_PCI].en;
  assign pci_hiz  = fin[GRP_PCI].hiz;
  assign usb_freq = fin[GRP_USB].freq;
  assign usb_en   = fin[GRP_USB].en;
  assign usb_hiz  = fin[GRP_USB].hiz;
  assign ref_freq = fin[GRP_REF].freq;
  assign ref_en   = fin[GRP_REF].en;
  assign ref_hiz  = fin[GRP_REF].hiz;

  assign osc_en        = !pd_active;
  assign cpu_park_high = cap_done && pd_active;
  assign cpu_spread    = spread_req && fin[GRP_CPU].en;
  assign rsvd_flag     = cap_done && dec_rsvd;

  always_comb begin
    if (pd_active) cpu_imult = IMULT_PD;
    else begin
      unique case (swing_sel)
        2'b00: cpu_imult = 3'd5;
        2'b01: cpu_imult = 3'd6;
        2'b10: cpu_imult = 3'd4;
        default: cpu_imult = 3'd7;
      endcase
    end
  end
endmodule

// File: rtl/clkgen_mode_ctrl_chk.sv
module clkgen_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cap_done,
  input logic       pd_active,
  input logic [2:0] mode_idx,
  input logic       osc_en,
  input logic [2:0] cpu_freq,
  input logic       cpu_en,
  input logic       cpu_hiz,
  input logic       cpu_spread,
  input logic       cpu_park_high,
  input logic [2:0] cpu_imult,
  input logic [2:0] pci_freq,
  input logic       pci_en,
  input logic       pci_hiz,
  input logic [2:0] usb_freq,
  input logic       usb_en,
  input logic       usb_hiz,
  input logic [2:0] ref_freq,
  input logic       ref_en,
  input logic       ref_hiz,
  input logic       rsvd_flag
);
  assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cap_done)) |-> $stable(mode_idx[1:0]));

  assert_usb_tristate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_done |-> (usb_hiz && !usb_en));

  assert_en_not_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !((cpu_en && cpu_hiz) || (pci_en && pci_hiz) ||
      (usb_en && usb_hiz) || (ref_en && ref_hiz)));

  assert_no_undef_freq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_freq != 3'd7) && (pci_freq != 3'd7) &&
    (usb_freq != 3'd7) && (ref_freq != 3'd7));

  assert_rsvd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_flag |-> !(cpu_en || pci_en || usb_en || ref_en));

  assert_pd_levels_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && cap_done) |-> (!osc_en && cpu_park_high && !cpu_en &&
      !ref_en && !ref_hiz && !pci_en && (cpu_imult == 3'd2)));

  assert_pd_exit_settle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_active) |-> (!cpu_en && !pci_en && !usb_en && !ref_en && osc_en));

  assert_spread_cpu_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_spread |-> cpu_en);

  assert_imult_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_active |-> (cpu_imult >= 3'd4));
endmodule

bind clkgen_mode_ctrl clkgen_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cap_done(cap_done), .pd_active(pd_active),
  .mode_idx(mode_idx), .osc_en(osc_en), .cpu_freq(cpu_freq), .cpu_en(cpu_en),
  .cpu_hiz(cpu_hiz), .cpu_spread(cpu_spread), .cpu_park_high(cpu_park_high),
  .cpu_imult(cpu_imult), .pci_freq(pci_freq), .pci_en(pci_en), .pci_hiz(pci_hiz),
  .usb_freq(usb_freq), .usb_en(usb_en), .usb_hiz(usb_hiz), .ref_freq(ref_freq),
  .ref_en(ref_en), .ref_hiz(ref_hiz), .rsvd_flag(rsvd_flag)
);

// File: tb/clkgen_mode_ctrl_tb.sv
module clkgen_mode_ctrl_tb;
  localparam int SYNC = 2;
  localparam int HOLD = 4;
  localparam int STAB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_hi = 1'b0, strap0_pin = 1'b0, strap1_pin = 1'b0;
  logic pwrdn_n = 1'b1, spread_n = 1'b1;
  logic [1:0] swing_sel = 2'b00;
  logic [2:0] mode_idx, cpu_freq, cpu_imult, pci_freq, usb_freq, ref_freq;
  logic osc_en, cpu_en, cpu_hiz, cpu_spread, cpu_park_high;
  logic pci_en, pci_hiz, usb_en, usb_hiz, ref_en, ref_hiz, rsvd_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  clkgen_mode_ctrl #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD), .STAB_CYCLES(STAB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_hi(sel_hi), .strap0_pin(strap0_pin),
    .strap1_pin(strap1_pin), .pwrdn_n(pwrdn_n), .spread_n(spread_n),
    .swing_sel(swing_sel), .mode_idx(mode_idx), .osc_en(osc_en),
    .cpu_freq(cpu_freq), .cpu_en(cpu_en), .cpu_hiz(cpu_hiz),
    .cpu_spread(cpu_spread), .cpu_park_high(cpu_park_high), .cpu_imult(cpu_imult),
    .pci_freq(pci_freq), .pci_en(pci_en), .pci_hiz(pci_hiz),
    .usb_freq(usb_freq), .usb_en(usb_en), .usb_hiz(usb_hiz),
    .ref_freq(ref_freq), .ref_en(ref_en), .ref_hiz(ref_hiz), .rsvd_flag(rsvd_flag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Advance n edges; sample 2 ns after the last one.
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Group state packed as {freq, en, hiz}.
  function automatic int grp(input logic [2:0] f, input logic e, input logic h);
    return {f, e, h};
  endfunction

  task automatic boot(input logic s0, input logic s1, input logic pd_n);
    rst_n = 1'b0; strap0_pin = s0; strap1_pin = s1; pwrdn_n = pd_n;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; sel_hi = 1'b0; tick(2);
    chk("R3", "usb_hiz in reset", usb_hiz, 1);
    chk("R1", "cpu_en in reset", cpu_en, 0);
    chk("R8", "rsvd_flag in reset", rsvd_flag, 0);
  endtask

  task automatic t_hold;
    sel_hi = 1'b0; boot(1'b0, 1'b0, 1'b1);
    tick(HOLD);
    chk("R3", "usb_hiz at end of hold", usb_hiz, 1);
    chk("R1", "cpu running after capture", cpu_en, 1);
    tick(1);
    chk("R3", "usb after hold", grp(usb_freq, usb_en, usb_hiz), grp(3'd5, 1, 0));
  endtask

  task automatic t_mode(input logic [2:0] m);
    int ec, ep, eu, er;
    sel_hi = m[2]; boot(m[1], m[0], 1'b1);
    tick(HOLD + 1);
    chk("R1", "mode_idx", mode_idx, m);
    case (m)
      3'b000: begin ec = grp(1,1,0); ep = grp(4,1,0); eu = grp(5,1,0); er = grp(6,1,0); end
      3'b001: begin ec = grp(1,1,0); ep = grp(4,1,0); eu = grp(0,0,0); er = grp(6,1,0); end
      3'b010: begin ec = grp(1,1,0); ep = grp(0,0,0); eu = grp(0,0,0); er = grp(6,1,0); end
      3'b011: begin ec = grp(0,0,1); ep = grp(0,0,1); eu = grp(0,0,1); er = grp(0,0,1); end
      3'b100: begin ec = grp(2,1,0); ep = grp(4,1,0); eu = grp(5,1,0); er = grp(6,1,0); end
      3'b101: begin ec = grp(2,1,0); ep = grp(4,1,0); eu = grp(0,0,0); er = grp(6,1,0); end
      3'b110: begin ec = grp(3,1,0); ep = grp(4,1,0); eu = grp(5,1,0); er = grp(6,1,0); end
      default: begin ec = grp(0,0,0); ep = grp(0,0,0); eu = grp(0,0,0); er = grp(0,0,0); end
    endcase
    chk(m == 3'b011 ? "R7" : (m == 3'b111 ? "R8" : "R4"), $sformatf("cpu mode %b", m),
        grp(cpu_freq, cpu_en, cpu_hiz), ec);
    chk("R5", $sformatf("pci mode %b", m), grp(pci_freq, pci_en, pci_hiz), ep);
    chk("R6", $sformatf("usb mode %b", m), grp(usb_freq, usb_en, usb_hiz), eu);
    chk("R13", $sformatf("ref mode %b", m), grp(ref_freq, ref_en, ref_hiz), er);
    chk("R8", $sformatf("rsvd_flag mode %b", m), rsvd_flag, (m == 3'b111) ? 1 : 0);
  endtask

  task automatic t_strap_ignore;
    sel_hi = 1'b1; boot(1'b1, 1'b0, 1'b1);
    tick(HOLD + 1);
    for (int i = 0; i < 24; i++) begin
      strap0_pin = i[0]; strap1_pin = i[1];
      tick(1);
    end
    chk("R2", "mode_idx after pin activity", mode_idx, 3'b110);
    chk("R2", "cpu freq after pin activity", cpu_freq, 3);
    sel_hi = 1'b0; #1;
    chk("R1", "sel_hi acts live", mode_idx, 3'b010);
    chk("R2", "pci follows latched straps", pci_en, 0);
  endtask

  task automatic t_pd;
    sel_hi = 1'b0; boot(1'b0, 1'b0, 1'b1);
    tick(HOLD + 1);
    pwrdn_n = 1'b0;
    tick(SYNC - 1);
    chk("R9", "still running before sync", cpu_en, 1);
    tick(1);
    chk("R9", "osc_en in pd", osc_en, 0);
    chk("R9", "cpu_park_high in pd", cpu_park_high, 1);
    chk("R9", "cpu_imult in pd", cpu_imult, 2);
    chk("R9", "usb driven low", grp(usb_freq, usb_en, usb_hiz), grp(0,0,0));
    chk("R9", "ref driven low", grp(ref_freq, ref_en, ref_hiz), grp(0,0,0));
    chk("R9", "cpu stopped", cpu_en, 0);
    pwrdn_n = 1'b1;
    tick(SYNC + STAB - 1);
    chk("R10", "osc_en while settling", osc_en, 1);
    chk("R10", "park released while settling", cpu_park_high, 0);
    chk("R10", "cpu held off while settling", cpu_en, 0);
    chk("R10", "ref held off while settling", ref_en, 0);
    tick(1);
    chk("R10", "cpu back after settling", grp(cpu_freq, cpu_en, cpu_hiz), grp(1,1,0));
    chk("R10", "usb back after settling", usb_en, 1);
  endtask

  task automatic t_spread;
    sel_hi = 1'b1; boot(1'b0, 1'b0, 1'b1);
    tick(HOLD + 1);
    spread_n = 1'b0;
    tick(SYNC - 1);
    chk("R11", "spread before sync", cpu_spread, 0);
    tick(1);
    chk("R11", "spread on", cpu_spread, 1);
    chk("R11", "spread keeps cpu freq", cpu_freq, 2);
    sel_hi = 1'b0; boot(1'b1, 1'b1, 1'b1);
    tick(HOLD + 1);
    chk("R11", "no spread when cpu tri-stated", cpu_spread, 0);
    spread_n = 1'b1; tick(SYNC);
  endtask

  task automatic t_swing;
    sel_hi = 1'b0; boot(1'b0, 1'b0, 1'b1);
    tick(HOLD + 1);
    for (int s = 0; s < 4; s++) begin
      swing_sel = s[1:0]; #1;
      chk("R12", $sformatf("imult sel %0d", s), cpu_imult,
          (s == 0) ? 5 : (s == 1) ? 6 : (s == 2) ? 4 : 7);
    end
    swing_sel = 2'b00;
  endtask

  task automatic t_overlap;
    sel_hi = 1'b0; boot(1'b0, 1'b1, 1'b0);
    tick(SYNC);
    chk("R9", "ref low in pd during hold", grp(ref_freq, ref_en, ref_hiz), grp(0,0,0));
    chk("R3", "usb tri-stated over pd", usb_hiz, 1);
    tick(HOLD + 1 - SYNC);
    chk("R9", "usb driven low after hold in pd", grp(usb_freq, usb_en, usb_hiz), grp(0,0,0));
    chk("R2", "straps kept", mode_idx, 3'b001);
    pwrdn_n = 1'b1;
    tick(SYNC + STAB);
    chk("R10", "cpu runs after pd", cpu_en, 1);
    chk("R6", "usb disabled in mode 001", grp(usb_freq, usb_en, usb_hiz), grp(0,0,0));
  endtask

  initial begin
    tick(1);
    t_reset();
    t_hold();
    for (int m = 0; m < 8; m++) t_mode(m[2:0]);
    t_strap_ignore();
    t_pd();
    t_spread();
    t_swing();
    t_overlap();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule